// File: doc/BRIEF.md
# Indirect Internal Register Window

This block gives a host a narrow view into a much larger internal space. Four 32-bit host registers sit at word offsets from a base: a command register, a channel parameter register, an address register, and a data register. The address register shares its word with a read-only interrupt status half-word. A host reaches an internal register or an internal RAM word by loading the address register first. It then reads or writes the data register, and each such access is forwarded in the same cycle to the internal register bus or to the RAM port.

The address register has the following fields. Bits [AW-1:0] hold the internal byte address. Bits [13:12] select a 32-bit slice of a 68-bit RAM word. Bit 14 directs data accesses to the RAM port instead of the register bus. Bit 15 turns on post-increment: the address field steps by 4 after every data access, so a block of statistics or RAM can be streamed without rewriting the address. Host byte enables limit every write to the enabled lanes.

Top module: `ireg_window`

## Requirements
- R1: After reset the command, channel parameter and address registers read as zero.
- R2: Host word offset 0 is the command register, 1 is the channel parameter register, 2 holds the address register in bits [15:0] and the interrupt status input in bits [31:16], and 3 is the data register. Offsets 0, 1 and 2 read back what was written.
- R3: With address bit 14 clear, a data-register write drives `ib_wr`, `ib_wdata` and `ib_be` in that cycle with `ib_addr` equal to address bits [AW-1:0]. A data-register read drives a `ib_rd` strobe for that cycle only and returns `ib_rdata` in the same cycle. The read and write strobes are never high together.
- R4: With address bit 15 set, every data-register access, read or write, adds 4 to the address field on the next clock edge.
- R5: With address bit 15 clear, data-register accesses leave the address register unchanged.
- R6: The increment wraps within the AW-bit address field and never alters bits [15:12].
- R7: With bit 14 set and selector 00, the data register maps to bits [31:0] of the RAM word for both reads and writes.
- R8: With bit 14 set and selector 01, the data register maps to bits [63:32] of the RAM word.
- R9: With bit 14 set and selector 1x, the data register maps to bits [67:64] of the RAM word, carried in data bits [3:0]. The upper 28 read bits are zero, and a write is enabled by byte lane 0 alone.
- R10: Byte enable bit n gates host data bits [8n+7:8n] for the command, channel parameter and internal-bus writes, and for the RAM write mask of the selected slice.
- R11: Writes to bits [31:16] of offset 2 have no effect; those bits always read the interrupt status input.
- R12: With bit 14 set, data accesses drive `ram_rd`/`ram_wr` and leave `ib_rd`/`ib_wr` low. `ram_addr` is address bits [AW-1:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_sel | input | 1 | Host access strobe, one cycle per access |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_off | input | 2 | Host register word offset |
| hst_be | input | 4 | Host byte enables |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, valid in the access cycle |
| int_stat | input | 16 | Interrupt status shown in the upper half of offset 2 |
| cmd_q | output | 32 | Command register contents |
| chparm_q | output | 32 | Channel parameter register contents |
| ib_addr | output | AW | Internal register bus byte address |
| ib_rd | output | 1 | Internal read strobe |
| ib_wr | output | 1 | Internal write strobe |
| ib_be | output | 4 | Internal write byte enables |
| ib_wdata | output | 32 | Internal write data |
| ib_rdata | input | 32 | Internal read data |
| ram_addr | output | AW-2 | RAM word address |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| ram_wdata | output | 68 | RAM write data, the host word placed in every slice |
| ram_wmask | output | 68 | RAM per-bit write mask |
| ram_rdata | input | 68 | RAM read data |

## Verification
The bus strobes, forwarded address, masks and read data are combinational, so they are due in the cycle of the host access itself. The bench samples them two nanoseconds after driving the access, before the rising edge. Register writes and the post-increment take effect at that edge. They are observed through a separate offset-2 read or through `ib_addr` on the following access. The single-cycle nature of `ib_rd` is checked in the idle cycle that follows each read.

// File: rtl/ireg_window.sv
module ireg_window #(
  parameter int AW = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hst_sel,
  input  logic        hst_we,
  input  logic [1:0]  hst_off,
  input  logic [3:0]  hst_be,
  input  logic [31:0] hst_wdata,
  output logic [31:0] hst_rdata,
  input  logic [15:0] int_stat,
  output logic [31:0] cmd_q,
  output logic [31:0] chparm_q,
  output logic [AW-1:0] ib_addr,
  output logic        ib_rd,
  output logic        ib_wr,
  output logic [3:0]  ib_be,
  output logic [31:0] ib_wdata,
  input  logic [31:0] ib_rdata,
  output logic [AW-3:0] ram_addr,
  output logic        ram_rd,
  output logic        ram_wr,
  output logic [67:0] ram_wdata,
  output logic [67:0] ram_wmask,
  input  logic [67:0] ram_rdata
);
  localparam int INC_B = 15;
  localparam int RAM_B = 14;
  localparam logic [AW-1:0] STEP = AW'(4);

  logic [15:0] adr_q;
  logic [31:0] bmask, ram_slice;

  wire d_acc = hst_sel && (hst_off == 2'd3);
  wire to_ram = adr_q[RAM_B];

  always_comb
    for (int i = 0; i < 4; i++) bmask[8*i +: 8] = {8{hst_be[i]}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adr_q    <= '0;
      cmd_q    <= '0;
      chparm_q <= '0;
    end else begin
      if (hst_sel && hst_we) begin
        case (hst_off)
          2'd0: cmd_q    <= (cmd_q & ~bmask) | (hst_wdata & bmask);
          2'd1: chparm_q <= (chparm_q & ~bmask) | (hst_wdata & bmask);
          2'd2: adr_q    <= (adr_q & ~bmask[15:0]) | (hst_wdata[15:0] & bmask[15:0]);
          default: ;
        endcase
      end
      if (d_acc && adr_q[INC_B])
        adr_q[AW-1:0] <= adr_q[AW-1:0] + STEP;
    end
  end

  assign ib_addr  = adr_q[AW-1:0];
  assign ib_rd    = d_acc && !hst_we && !to_ram;
  assign ib_wr    = d_acc && hst_we && !to_ram;
  assign ib_be    = hst_be;
  assign ib_wdata = hst_wdata;

  assign ram_addr  = adr_q[AW-1:2];
  assign ram_rd    = d_acc && !hst_we && to_ram;
  assign ram_wr    = d_acc && hst_we && to_ram;
  assign ram_wdata = {hst_wdata[3:0], hst_wdata, hst_wdata};

  always_comb begin
    ram_wmask = '0;
    case (adr_q[13:12])
      2'b00:   begin ram_wmask[31:0]  = bmask; ram_slice = ram_rdata[31:0]; end
      2'b01:   begin ram_wmask[63:32] = bmask; ram_slice = ram_rdata[63:32]; end
      default: begin ram_wmask[67:64] = {4{hst_be[0]}}; ram_slice = {28'd0, ram_rdata[67:64]}; end
    endcase
  end

  always_comb
    case (hst_off)
      2'd0:    hst_rdata = cmd_q;
      2'd1:    hst_rdata = chparm_q;
      2'd2:    hst_rdata = {int_stat, adr_q};
      default: hst_rdata = to_ram ? ram_slice : ib_rdata;
    endcase
endmodule

module ireg_window_chk #(
  parameter int AW = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        hst_sel,
  input logic [1:0]  hst_off,
  input logic [15:0] adr_q,
  input logic        ib_rd,
  input logic        ib_wr,
  input logic        ram_rd,
  input logic        ram_wr,
  input logic [67:0] ram_wmask
);
  wire dacc = hst_sel && hst_off == 2'd3;

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(ib_rd && ib_wr)); // R3
  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dacc && adr_q[15] |=> adr_q[AW-1:0] == AW'($past(adr_q[AW-1:0]) + AW'(4))); // R4
  AST_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dacc && !adr_q[15] |=> $stable(adr_q)); // R5
  AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    dacc |=> adr_q[15:12] == $past(adr_q[15:12])); // R6
  AST_TOP_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr && adr_q[13] |-> ram_wmask[63:0] == 64'd0); // R9
  AST_PATH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !((ib_rd || ib_wr) && (ram_rd || ram_wr))); // R12
endmodule

bind ireg_window ireg_window_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_off(hst_off), .adr_q(adr_q),
  .ib_rd(ib_rd), .ib_wr(ib_wr), .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_wmask(ram_wmask)
);

// File: tb/ireg_window_tb.sv
module ireg_window_tb_top;
  localparam int AW = 12;
  logic clk = 0, rst_n = 0;
  logic hst_sel = 0, hst_we = 0;
  logic [1:0] hst_off = 0;
  logic [3:0] hst_be = 0;
  logic [31:0] hst_wdata = 0, hst_rdata;
  logic [15:0] int_stat = 16'hBEEF;
  logic [31:0] cmd_q, chparm_q, ib_wdata, ib_rdata;
  logic [AW-1:0] ib_addr;
  logic ib_rd, ib_wr, ram_rd, ram_wr;
  logic [3:0] ib_be;
  logic [AW-3:0] ram_addr;
  logic [67:0] ram_wdata, ram_wmask, ram_rdata;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  assign ib_rdata  = 32'hD000_0000 | 32'(ib_addr);
  assign ram_rdata = {4'hC, 32'h1111_0000 | 32'(ram_addr), 32'h2222_0000 | 32'(ram_addr)};

  ireg_window #(.AW(AW)) dut_i (.*);

  logic [31:0] s_rd, s_ibw;
  logic [AW-1:0] s_iba;
  logic [3:0] s_ibbe;
  logic s_ibrd, s_ibwr, s_rrd, s_rwr;
  logic [67:0] s_wm, s_wd;

  task automatic chk(input string tag, input logic [67:0] got, input logic [67:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus(input logic we, input logic [1:0] off, input logic [3:0] be, input logic [31:0] wd);
    @(negedge clk);
    hst_sel = 1; hst_we = we; hst_off = off; hst_be = be; hst_wdata = wd;
    #2;
    s_rd = hst_rdata; s_iba = ib_addr; s_ibrd = ib_rd; s_ibwr = ib_wr; s_ibbe = ib_be;
    s_ibw = ib_wdata; s_rrd = ram_rd; s_rwr = ram_wr; s_wm = ram_wmask; s_wd = ram_wdata;
    @(negedge clk);
    hst_sel = 0; hst_we = 0;
  endtask

  task automatic t_reset;
    bus(0, 0, 0, 0); chk("R1 cmd", s_rd, 0);
    bus(0, 1, 0, 0); chk("R1 chparm", s_rd, 0);
    bus(0, 2, 0, 0); chk("R1/R2 adr+int", s_rd, 32'hBEEF_0000);
  endtask

  task automatic t_map;
    bus(1, 0, 4'hF, 32'h1122_3344);
    bus(1, 1, 4'hF, 32'h5566_7788);
    bus(0, 0, 0, 0); chk("R2 cmd", s_rd, 32'h1122_3344);
    bus(0, 1, 0, 0); chk("R2 chparm", s_rd, 32'h5566_7788);
    chk("R2 chparm_q", chparm_q, 32'h5566_7788);
  endtask

  task automatic t_bytes;
    bus(1, 0, 4'b0010, 32'hFFFF_FFFF);
    bus(0, 0, 0, 0); chk("R10 cmd lane1", s_rd, 32'h1122_FF44);
  endtask

  task automatic t_int_ignore;
    bus(1, 2, 4'hF, 32'hDEAD_0040);
    bus(0, 2, 0, 0); chk("R11 int half", s_rd, 32'hBEEF_0040);
  endtask

  task automatic t_ireg;
    bus(1, 3, 4'b0101, 32'hCAFE_0001);
    chk("R3 wr", {s_ibwr, s_ibrd}, 2'b10);
    chk("R3 addr", s_iba, 12'h040);
    chk("R3 wdata", s_ibw, 32'hCAFE_0001);
    chk("R10 ib_be", s_ibbe, 4'b0101);
    bus(0, 3, 0, 0);
    chk("R3 rdata", s_rd, 32'hD000_0040);
    chk("R3 rd strobe", {s_ibrd, s_ibwr}, 2'b10);
    #2 chk("R3 rd one cycle", ib_rd, 0);
    bus(0, 2, 0, 0); chk("R5 no inc", s_rd, 32'hBEEF_0040);
  endtask

  task automatic t_autoinc;
    bus(1, 2, 4'b0011, 32'h0000_8100);
    for (int k = 0; k < 3; k++) begin
      bus(0, 3, 0, 0);
      chk("R4 stream addr", s_iba, 12'(12'h100 + 4 * k));
      chk("R4 stream data", s_rd, 32'hD000_0100 + 32'(4 * k));
    end
    bus(1, 3, 4'hF, 32'h1);
    bus(0, 2, 0, 0); chk("R4 after write", s_rd, 32'hBEEF_8110);
  endtask

  task automatic t_wrap;
    bus(1, 2, 4'b0011, 32'h0000_BFFC);
    bus(0, 3, 0, 0);
    bus(0, 2, 0, 0); chk("R6 wrap", s_rd, 32'hBEEF_B000);
  endtask

  task automatic t_ram;
    bus(1, 2, 4'b0011, 32'h0000_4010);
    bus(0, 3, 0, 0);
    chk("R7 low slice", s_rd, 32'h2222_0004);
    chk("R12 paths", {s_rrd, s_rwr, s_ibrd, s_ibwr}, 4'b1000);
    bus(1, 3, 4'b0011, 32'hAAAA_5555);
    chk("R7 wmask", s_wm, 68'h0_0000_0000_0000_FFFF);
    chk("R12 wr path", {s_rwr, s_ibwr}, 2'b10);
    bus(1, 2, 4'b0011, 32'h0000_5010);
    bus(0, 3, 0, 0); chk("R8 mid slice", s_rd, 32'h1111_0004);
    bus(1, 3, 4'b1100, 32'h1234_5678);
    chk("R8/R10 wmask", s_wm, 68'h0_FFFF_0000_0000_0000);
    chk("R8 wdata", s_wd[63:32], 32'h1234_5678);
    bus(1, 2, 4'b0011, 32'h0000_6010);
    bus(0, 3, 0, 0); chk("R9 top sel10", s_rd, 32'h0000_000C);
    bus(1, 2, 4'b0011, 32'h0000_7010);
    bus(0, 3, 0, 0); chk("R9 top sel11", s_rd, 32'h0000_000C);
    bus(1, 3, 4'b0001, 32'hFFFF_FFF5);
    chk("R9 wmask", s_wm, 68'hF_0000_0000_0000_0000);
    chk("R9 wdata", s_wd[67:64], 4'h5);
    bus(1, 3, 4'b1110, 32'hFFFF_FFF5);
    chk("R9 lane0 only", s_wm, 68'h0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_map(); t_bytes(); t_int_ignore(); t_ireg();
    t_autoinc(); t_wrap(); t_ram();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule